// File: doc/BRIEF.md
# Sawtooth Staircase Tone Voice

This block produces one sawtooth voice for a sound generator. A programmable 12-bit period down-counter runs at the system clock. Each time it expires, it advances a 14-position phase counter. On every second phase position, a 6-bit rate value is added into an 8-bit accumulator. When the phase counter wraps, the accumulator returns to zero. The top five accumulator bits form the sample. The result is a seven-level staircase whose height depends on the rate.

Two global scale controls shorten the period by a right shift of 4 or 8 bits, which raises the pitch by four or eight octaves. A halt control freezes the whole voice. An enable control forces the sample to zero without disturbing the accumulator. When the rate is large, the accumulator wraps modulo 256. This wrap is modelled exactly and produces a deliberately distorted ramp.

Top module: `saw_voice`

## Requirements
- R1: When not halted, the period counter decrements once per clock. In a clock where it holds 0, it reloads with the effective period and issues one phase tick, so ticks are spaced effective period + 1 clocks apart.
- R2: Each tick advances the phase position by one within 0..13. A tick that lands on an even position (2, 4, 6, 8, 10 or 12) adds the zero-extended rate to the accumulator. A tick that lands on an odd position leaves the accumulator unchanged.
- R3: A tick taken while the phase position is 13 returns the position to 0 and clears the accumulator to 0 instead of adding.
- R4: The sample is accumulator bits 7..3. With rate 8 and effective period 0, the sample runs 0,0,1,1,2,2,3,3,4,4,5,5,6,6 and then repeats.
- R5: The accumulator is 8 bits and wraps modulo 256. For example, rate 63 gives accumulator values 63, 126, 189, 252, 59, 122.
- R6: While enable is 0 the sample is 0. The counter, phase and accumulator keep running, so re-enabling shows the accumulator value reached in the meantime.
- R7: While halt is 1, the period counter, phase position and accumulator all hold their values, whatever the scale controls are set to.
- R8: The effective period is period >> 8 when scale256 is 1 (regardless of scale16), period >> 4 when only scale16 is 1, and period otherwise.
- R9: Reset, asynchronous and active low, clears the period counter, phase position and accumulator. The first clock after reset therefore issues a tick, and the sample reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 12 | Period reload value |
| rate | input | 6 | Value added to the accumulator on even phase positions |
| enable | input | 1 | Sample gate; 0 forces the sample to 0 |
| halt | input | 1 | Freezes all voice state |
| scale16 | input | 1 | Use period >> 4 |
| scale256 | input | 1 | Use period >> 8; overrides scale16 |
| sample | output | 5 | Upper five accumulator bits, gated by enable |

## Verification
Only the five-bit sample is visible at the ports. A faulty counter, phase position or accumulator therefore appears as a staircase step that arrives on the wrong clock, holds the wrong level, or fails to return to zero. With short periods, any such fault shows within one 14-tick cycle of the ramp, which is at most a few dozen clocks. A wrong accumulator hidden behind enable = 0 shows up on the first clock after re-enabling. A wrong reload value only shows once the voice runs, so checks are sampled every clock against a cycle-accurate expected value. Directed scale cases pin down the exact clock of the first rising step.

// File: rtl/saw_pkg.sv
package saw_pkg;
    localparam int PERIOD_W = 12;
    localparam int RATE_W   = 6;
    localparam int ACC_W    = 8;
    localparam int SAMPLE_W = 5;
    localparam int PHASES   = 14;
    localparam int SHIFT_MID = 4;
    localparam int SHIFT_HI  = 8;

    typedef enum logic [1:0] {
        SPEED_HOLD = 2'd0,
        SPEED_X1   = 2'd1,
        SPEED_X16  = 2'd2,
        SPEED_X256 = 2'd3
    } speed_e;
endpackage

// File: rtl/saw_divider.sv
module saw_divider
    import saw_pkg::*;
#(
    parameter int PW     = PERIOD_W,
    parameter int SH_MID = SHIFT_MID,
    parameter int SH_HI  = SHIFT_HI
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    input  logic          halt,
    input  logic          scale16,
    input  logic          scale256,
    output logic          tick,
    output logic [PW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;
    speed_e     speed;
    logic [PW-1:0] reload_val;

    always_comb begin
        if (halt)          speed = SPEED_HOLD;
        else if (scale256) speed = SPEED_X256;
        else if (scale16)  speed = SPEED_X16;
        else               speed = SPEED_X1;

        case (speed)
            SPEED_X256: reload_val = period >> SH_HI;
            SPEED_X16:  reload_val = period >> SH_MID;
            default:    reload_val = period;
        endcase

        tick    = (speed != SPEED_HOLD) && (state_q.cnt == '0);
        state_d = state_q;
        if (speed != SPEED_HOLD) begin
            if (state_q.cnt == '0) state_d.cnt = reload_val;
            else                   state_d.cnt = state_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.cnt;
endmodule

// File: rtl/saw_phase.sv
module saw_phase
    import saw_pkg::*;
#(
    parameter int RW     = RATE_W,
    parameter int AW     = ACC_W,
    parameter int NSTEPS = PHASES,
    localparam int SW    = $clog2(NSTEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    output logic [SW-1:0] step,
    output logic [AW-1:0] acc
);
    localparam logic [SW-1:0] LAST_STEP = SW'(NSTEPS - 1);

    typedef struct packed {
        logic [SW-1:0] step;
        logic [AW-1:0] acc;
    } phase_state_t;

    phase_state_t state_d, state_q;
    logic [SW-1:0] step_inc;
    logic [AW-1:0] rate_ext;

    always_comb begin
        rate_ext = {{(AW-RW){1'b0}}, rate};
        step_inc = state_q.step + 1'b1;
        state_d  = state_q;
        if (tick) begin
            if (state_q.step == LAST_STEP) begin
                state_d.step = '0;
                state_d.acc  = '0;
            end else begin
                state_d.step = step_inc;
                if (!step_inc[0]) state_d.acc = state_q.acc + rate_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign step = state_q.step;
    assign acc  = state_q.acc;
endmodule

// File: rtl/saw_gate.sv
module saw_gate
    import saw_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int OW = SAMPLE_W
) (
    input  logic [AW-1:0] acc,
    input  logic          enable,
    output logic [OW-1:0] sample
);
    always_comb begin
        if (enable) sample = acc[AW-1 -: OW];
        else        sample = '0;
    end
endmodule

// File: rtl/saw_voice.sv
module saw_voice
    import saw_pkg::*;
#(
    parameter int PW     = PERIOD_W,
    parameter int RW     = RATE_W,
    parameter int AW     = ACC_W,
    parameter int OW     = SAMPLE_W,
    parameter int NSTEPS = PHASES,
    localparam int SW    = $clog2(NSTEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    input  logic [RW-1:0] rate,
    input  logic          enable,
    input  logic          halt,
    input  logic          scale16,
    input  logic          scale256,
    output logic [OW-1:0] sample
);
    logic          tick_w;
    logic [PW-1:0] cnt_w;
    logic [SW-1:0] step_w;
    logic [AW-1:0] acc_w;

    saw_divider #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .period(period), .halt(halt),
        .scale16(scale16), .scale256(scale256), .tick(tick_w), .count(cnt_w)
    );

    saw_phase #(.RW(RW), .AW(AW), .NSTEPS(NSTEPS)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .rate(rate),
        .step(step_w), .acc(acc_w)
    );

    saw_gate #(.AW(AW), .OW(OW)) u_gate (
        .acc(acc_w), .enable(enable), .sample(sample)
    );
endmodule

// File: rtl/saw_voice_chk.sv
module saw_voice_chk #(
    parameter int PW = 12,
    parameter int AW = 8,
    parameter int OW = 5,
    parameter int SW = 4,
    parameter int NSTEPS = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          enable,
    input logic [OW-1:0] sample,
    input logic          tick,
    input logic [PW-1:0] cnt,
    input logic [SW-1:0] step,
    input logic [AW-1:0] acc
);
    // R1
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R2
    odd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !step[0]) |=> (acc == $past(acc)));

    // R3
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && step == SW'(NSTEPS - 1)) |=> (acc == '0 && step == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> ($stable(acc) && $stable(step)));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && enable) |=> (!enable || $stable(sample)));
endmodule

bind saw_voice saw_voice_chk #(.PW(PW), .AW(AW), .OW(OW), .SW(SW), .NSTEPS(NSTEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .halt(halt), .enable(enable), .sample(sample),
    .tick(tick_w), .cnt(cnt_w), .step(step_w), .acc(acc_w)
);

// File: tb/saw_voice_test.sv
`timescale 1ns/1ps
module saw_voice_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] period = '0;
    logic [5:0]  rate = '0;
    logic        enable = 1'b0, halt = 1'b0, scale16 = 1'b0, scale256 = 1'b0;
    logic [4:0]  sample;

    int total = 0, bad = 0;
    int m_cnt = 0, m_step = 0, m_acc = 0;

    always #2.5 clk = ~clk;

    saw_voice uut (.clk(clk), .rst_n(rst_n), .period(period), .rate(rate),
        .enable(enable), .halt(halt), .scale16(scale16), .scale256(scale256),
        .sample(sample));

    function automatic int eff_period(int p, bit s16, bit s256);
        if (s256) return p >> 8;
        if (s16)  return p >> 4;
        return p;
    endfunction

    function automatic int exp_sample();
        return enable ? ((m_acc >> 3) & 31) : 0;
    endfunction

    task automatic check(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_tick();
        if (halt) return;
        if (m_cnt == 0) begin
            m_cnt = eff_period(period, scale16, scale256);
            if (m_step == 13) begin
                m_step = 0;
                m_acc  = 0;
            end else begin
                m_step++;
                if (m_step % 2 == 0) m_acc = (m_acc + rate) % 256;
            end
        end else begin
            m_cnt--;
        end
    endtask

    // one clock: inputs already set at negedge
    task automatic cyc();
        @(posedge clk);
        model_tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_cnt = 0; m_step = 0; m_acc = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        // R9 reset state
        enable = 1'b1; rate = 6'd8;
        do_reset();
        check("R9", sample, 0);

        // R4 staircase with rate 8, period 0
        for (int k = 1; k <= 30; k++) begin
            cyc();
            check("R4", sample, (k % 14) / 2);
        end

        // R5 wrap with rate 63
        rate = 6'd63;
        do_reset();
        for (int k = 1; k <= 14; k++) begin
            cyc();
            check("R5", sample, exp_sample());
        end
        do_reset();
        for (int k = 1; k <= 10; k++) cyc();
        check("R5", sample, 59 >> 3);

        // R8 scale256 (and override of scale16): period 0x300 -> eff 3
        for (int v = 0; v < 3; v++) begin
            rate = 6'd8;
            period = (v == 2) ? 12'h030 : 12'h300;
            scale256 = (v != 2);
            scale16  = (v != 0);
            do_reset();
            for (int k = 1; k <= 4; k++) cyc();
            check("R8", sample, 0);
            cyc();
            check("R8", sample, 1);
            for (int k = 1; k <= 8; k++) cyc();
            check("R1", sample, 2);
        end
        scale16 = 0; scale256 = 0;

        // R1 tick spacing with period 2: ticks at clocks 1,4,7
        period = 12'd2;
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            cyc();
            check("R1", sample, (k >= 4) ? 1 : 0);
        end
        cyc();
        check("R1", sample, 1);

        // R7 halt freezes, also with scales set
        period = 0; rate = 6'd20;
        do_reset();
        for (int k = 1; k <= 5; k++) cyc();
        begin
            int held;
            held = sample;
            halt = 1; scale256 = 1; scale16 = 1;
            for (int k = 0; k < 20; k++) begin
                cyc();
                check("R7", sample, held);
            end
        end
        halt = 0; scale256 = 0; scale16 = 0;
        for (int k = 0; k < 6; k++) begin
            cyc();
            check("R7", sample, exp_sample());
        end

        // R6 enable gating keeps accumulator running
        do_reset();
        enable = 0;
        for (int k = 1; k <= 6; k++) begin
            cyc();
            check("R6", sample, 0);
        end
        enable = 1;
        #1;
        check("R6", sample, exp_sample());
        check("R6", sample, (6 * 0 + 60) >> 3);

        // R2 R3 random mix against the bench model
        do_reset();
        for (int blk = 0; blk < 80; blk++) begin
            int mode;
            mode = $urandom % 8;
            rate = 6'($urandom);
            period = (mode < 5) ? 12'($urandom % 6) : 12'($urandom);
            scale256 = (mode == 6);
            scale16 = (mode >= 5) && ($urandom % 2 == 1);
            enable = ($urandom % 5) != 0;
            halt = ($urandom % 8) == 0;
            #1;
            for (int k = 0; k < 40; k++) begin
                cyc();
                check("R2", sample, exp_sample());
            end
        end
        halt = 0; enable = 1; scale16 = 0; scale256 = 0; period = 1; rate = 6'd33;
        for (int k = 0; k < 100; k++) begin
            cyc();
            check("R3", sample, exp_sample());
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule